// File: doc/BRIEF.md
# Serial EEPROM Read Target

This block is a two-wire bus target that stands in for a small serial memory of 256 bytes, 8 bits each, and serves reads from it. The bus clock and data lines come in as plain inputs and are sampled by a much faster system clock. The block answers on the data line through an open-drain enable: when `sda_oe` is high the line is pulled low. The block finds START, repeated START and STOP conditions and checks the control byte against a fixed type code and three strap pins. It keeps a byte-address counter that lives on from one transaction to the next.

Three read forms are served. A current-address read sends the byte the counter points at. A random read first loads the counter through a write header and one address byte, then follows with a repeated START and a read header. A sequential read keeps streaming successive bytes for as long as the controller acknowledges each one, and wraps from the last byte to byte 0. Bus writes of data are outside the block's function. The memory contents are loaded through a synchronous backdoor write port.

Top module: `eeprom_read_target`

## Requirements
- R1: After reset `sda_oe` is low and the address counter is 0, so the first current-address read returns byte 0.
- R2: A control byte is acknowledged on the 9th SCL clock only when bits 7..4 equal 4'b1010 and bits 3..1 equal `dev_sel`; bit 0 is the R/W bit (1 = read). On a mismatch the byte is not acknowledged, and all later bytes are ignored until the next START or STOP. The counter is left unchanged.
- R3: After an acknowledged read header, the byte at the counter address is shifted out MSB first, one bit per SCL clock.
- R4: Between transactions the counter holds one more than the address of the last byte sent.
- R5: In a write header followed by one address byte, both bytes are acknowledged and the address byte loads the counter. A repeated START and a read header then return data starting at that address.
- R6: Each data byte that the controller acknowledges is followed by the byte at the next address.
- R7: The counter wraps from 255 to 0 both during a sequential read and between transactions.
- R8: When a data byte is not acknowledged, the block releases SDA. After the following STOP it is idle, and the counter points past the last byte sent.
- R9: `sda_oe` changes only while SCL is low.
- R10: A START in any state discards the partial byte and begins a new control byte. A STOP in any state releases SDA, returns the block to idle and leaves the counter as it was.
- R11: A data byte that follows the address byte in a write is not acknowledged and leaves the memory unchanged.
- R12: A backdoor write updates the stored byte, and later bus reads return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| dev_sel | input | SEL_W | Strap value that the select bits of the control byte must match |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | ADDR_W | Backdoor write address |
| bd_wdata | input | DATA_W | Backdoor write data |

## Verification
The bench builds the block with its defaults: an 8-bit address and data width, a 3-bit select strap tied to 3'b101, and a two-stage synchronizer. With 256 bytes, a random read placed at address 253 crosses the top of memory within a five-byte burst, which puts the R7 wrap within reach of a short test. With two synchronizer stages, an SCL half period of 8 system clocks leaves several cycles of margin between the block's SDA updates and the next SCL rise. Header mismatches are tried on the type nibble and on the select field. Both abort conditions are tried partway through a byte.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_TX,
    ST_HOST_ACK,
    ST_SKIP
  } rd_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_s
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [SEL_W-1:0]  dev_sel,
  input  logic [DATA_W-1:0] mem_q,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_load,
  output logic              byte_load
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  rd_state_e         state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] sh;
  logic              rw_bit;
  logic              host_ack;
  logic              hdr_match;
  logic              rx_state;

  assign hdr_match = (sh[DATA_W-1 -: 4] == DEV_TYPE) &&
                     (sh[DATA_W-5 -: SEL_W] == dev_sel);
  assign rx_state  = (state == ST_CTRL) || (state == ST_ADDR);
  assign addr_load = (state == ST_ADDR) && scl_fall && (bitcnt == FULL);
  assign byte_load = scl_fall &&
                     (((state == ST_CTRL_ACK) && rw_bit) ||
                      ((state == ST_HOST_ACK) && host_ack));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      rw_bit   <= 1'b0;
      host_ack <= 1'b0;
      addr_q   <= '0;
      sda_oe   <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_CTRL;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (rx_state && scl_rise && (bitcnt < FULL)) begin
        sh     <= {sh[DATA_W-2:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (byte_load) begin
        sh     <= mem_q;
        sda_oe <= ~mem_q[DATA_W-1];
        bitcnt <= '0;
        addr_q <= addr_q + 1'b1;
        state  <= ST_TX;
      end else begin
        unique case (state)
          ST_CTRL: begin
            if (scl_fall && (bitcnt == FULL)) begin
              if (hdr_match) begin
                sda_oe <= 1'b1;
                rw_bit <= sh[0];
                state  <= ST_CTRL_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_CTRL_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_ADDR;
            end
          end
          ST_ADDR: begin
            if (addr_load) begin
              addr_q <= sh[ADDR_W-1:0];
              sda_oe <= 1'b1;
              state  <= ST_ADDR_ACK;
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_SKIP;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_HOST_ACK;
              end else begin
                sh     <= {sh[DATA_W-2:0], 1'b0};
                sda_oe <= ~sh[DATA_W-2];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_HOST_ACK: begin
            if (scl_rise) host_ack <= ~sda_s;
            if (scl_fall) state <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_read_target.sv
module eeprom_read_target #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [SEL_W-1:0]  dev_sel,
  input  logic              bd_we,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic [DATA_W-1:0] bd_wdata
);
  logic              scl_rise, scl_fall, start_evt, stop_evt, sda_s;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mem_q;
  logic              addr_load, byte_load;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s)
  );

  eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(bd_we), .waddr(bd_addr), .wdata(bd_wdata),
    .raddr(addr_q), .rdata(mem_q)
  );

  i2c_rd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .dev_sel(dev_sel), .mem_q(mem_q), .sda_oe(sda_oe),
    .addr_q(addr_q), .addr_load(addr_load), .byte_load(byte_load)
  );
endmodule

// File: rtl/eeprom_read_target_chk.sv
module eeprom_read_target_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_evt,
  input logic              stop_evt,
  input logic [ADDR_W-1:0] addr_q,
  input logic              addr_load,
  input logic              byte_load
);
  assert_release_reset_R1: assert property (@(posedge clk)
    rst |=> !sda_oe);

  assert_sda_quiet_high_R9: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  assert_start_release_R10: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !sda_oe);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    ((addr_q != $past(addr_q)) && !$past(addr_load))
      |-> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  assert_load_advance_R6: assert property (@(posedge clk) disable iff (rst)
    byte_load |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
endmodule

bind eeprom_read_target eeprom_read_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .addr_q(addr_q),
  .addr_load(addr_load), .byte_load(byte_load)
);

// File: tb/eeprom_read_target_test.sv
module eeprom_read_target_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_bus;
  logic [2:0] sel = 3'b101;
  logic       bd_we = 1'b0;
  logic [7:0] bd_addr = '0, bd_wdata = '0;

  assign sda_bus = sda_m & ~sda_oe;

  eeprom_read_target uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(sel), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata)
  );

  int runs = 0, fails = 0, viol = 0;
  logic [7:0] model [256];
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];
  int         ptr;
  logic       prev_oe = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(8); sda_m = 1'b0; wt(8); scl_m = 1'b0; wt(4);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wt(4); scl_m = 1'b1; wt(8); sda_m = 1'b1; wt(8);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0; wt(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4); ack = !sda_bus; wt(4); scl_m = 1'b0; wt(4);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(4); scl_m = 1'b1; wt(4); b = {b[6:0], sda_bus}; wt(4); scl_m = 1'b0;
    end
    wt(4); sda_m = give_ack ? 1'b0 : 1'b1; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0; wt(4);
    sda_m = 1'b1;
  endtask

  // driver: pushes expected bytes, then clocks them in
  task automatic read_seq(input int a0, input int n, input string tag0, input string tagn);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[(a0 + k) % 256]);
      tag_q.push_back(k == 0 ? tag0 : tagn);
      recv_byte(k < n - 1, b);
      got_q.push_back(b);
    end
    ptr = (a0 + n) % 256;
  endtask

  function automatic logic [7:0] hdr(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  // monitor: pops and compares as results arrive
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        if (exp_q.size() == 0) chk(0, "unexpected byte (R3)", g, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(g == e, t, g, e);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && scl_m && (sda_oe !== prev_oe)) viol++;
    prev_oe = sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    runs++; fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] junk;
    wt(2);
    for (int i = 0; i < 256; i++) begin
      model[i] = 8'((i * 29 + 11) ^ (i >> 3));
      bd_we = 1'b1; bd_addr = 8'(i); bd_wdata = model[i];
      wt(1);
    end
    bd_we = 1'b0;
    wt(4); rst = 1'b0; wt(4);

    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);

    // current-address read straight after reset
    start_c(); send_byte(hdr(sel, 1), ack);
    chk(ack, "R2 matching read header ack", ack, 1);
    read_seq(0, 1, "R1 R3 first read from address 0", "R3");
    stop_c();

    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(ptr, 1, "R4 counter persists across reads", "R4");
    stop_c();

    // select mismatch, then a good-looking byte with no START
    start_c(); send_byte(hdr(3'b010, 1), ack);
    chk(!ack, "R2 select mismatch nack", ack, 0);
    send_byte(hdr(sel, 1), ack);
    chk(!ack, "R2 ignored until START/STOP", ack, 0);
    stop_c();
    start_c(); send_byte({4'b1011, sel, 1'b1}, ack);
    chk(!ack, "R2 type nibble mismatch nack", ack, 0);
    stop_c();
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(ptr, 1, "R2 counter unchanged by mismatch", "R2");
    stop_c();

    // random read with a sequential burst
    start_c(); send_byte(hdr(sel, 0), ack);
    chk(ack, "R5 write header ack", ack, 1);
    send_byte(8'h40, ack);
    chk(ack, "R5 address byte ack", ack, 1);
    start_c(); send_byte(hdr(sel, 1), ack);
    chk(ack, "R5 read header after repeated START", ack, 1);
    read_seq(8'h40, 3, "R5 random read start byte", "R6 sequential next byte");
    stop_c();
    chk(sda_oe == 1'b0, "R8 released after NACK and STOP", sda_oe, 0);
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(ptr, 1, "R8 counter past last byte sent", "R8");
    stop_c();

    // wrap during a burst and between transactions
    start_c(); send_byte(hdr(sel, 0), ack); send_byte(8'hFD, ack);
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(8'hFD, 5, "R7 burst start near top", "R7 burst across 255 to 0");
    stop_c();
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(ptr, 1, "R7 counter after wrap", "R7");
    stop_c();
    start_c(); send_byte(hdr(sel, 0), ack); send_byte(8'hFF, ack);
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(8'hFF, 1, "R7 single read of byte 255", "R7");
    stop_c();
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(0, 1, "R7 counter wrapped to 0 between reads", "R7");
    stop_c();

    // data after the address in a write
    start_c(); send_byte(hdr(sel, 0), ack); send_byte(8'h10, ack);
    send_byte(8'h99, ack);
    chk(!ack, "R11 write data byte nack", ack, 0);
    stop_c();
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(8'h10, 1, "R11 memory unchanged by write data", "R11");
    stop_c();

    // START partway through a byte
    start_c(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    start_c(); send_byte(hdr(sel, 1), ack);
    chk(ack, "R10 START restarts control byte", ack, 1);
    read_seq(ptr, 1, "R10 read after mid-byte START", "R10");
    stop_c();

    // STOP partway through the address byte
    start_c(); send_byte(hdr(sel, 0), ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    stop_c();
    chk(sda_oe == 1'b0, "R10 STOP releases SDA", sda_oe, 0);
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(ptr, 1, "R10 counter untouched by aborted address", "R10");
    stop_c();

    // backdoor update
    wt(2);
    model[ptr] = 8'hC3;
    bd_we = 1'b1; bd_addr = 8'(ptr); bd_wdata = 8'hC3; wt(1); bd_we = 1'b0;
    wt(4);
    start_c(); send_byte(hdr(sel, 1), ack);
    read_seq(ptr, 1, "R12 backdoor value read back", "R12");
    stop_c();

    wt(8);
    chk(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);
    chk(viol == 0, "R9 sda_oe changed while SCL high", viol, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule